// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block forms the byte-merge datapath behind the four partial-word memory instructions of a little-endian 32-bit core: load-left, load-right, store-left and store-right. Each operation combines a word that already exists with bytes shifted out of a second word. The position of the split follows from the low two address bits. A load merges memory bytes into the old register value. A store merges register bytes into the old memory word, which is then written back to the aligned address.

The surrounding pipeline reads the aligned word. Because address bits [1:0] are ignored when the word is fetched, these operations never raise an alignment fault. The pipeline presents the offset, the aligned memory word, the current register value and the operation code, all qualified by a valid strobe. One cycle later the merged word comes back. For stores it comes with a byte-enable mask that marks the bytes that actually change, so the write can be done without a read-modify-write.

A pair of loads, left then right, assembles one misaligned word. Likewise, a pair of stores, right then left, writes one misaligned word. The width is set by a byte-count parameter (default 4).

Top module: `partial_word_merge`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `out_valid`=0, `out_word`=0 and `out_be`=0.
- R2: A request accepted with `in_valid`=1 yields its result with `out_valid`=1 after exactly one rising edge. After an edge with `in_valid`=0, `out_valid` is 0 and `out_word` holds its previous value.
- R3: Load-left (`in_op`=0) with offset k keeps register bytes below byte 3-k. It fills bytes 3-k..3 with memory bytes 0..k, meaning the memory word is shifted left by 8*(3-k) bits.
- R4: Load-right (`in_op`=1) with offset k keeps register bytes at and above byte 4-k. It fills the low 4-k bytes with memory bytes k..3, meaning the memory word is shifted right by 8*k bits. At offset 0 the result is the whole memory word.
- R5: Store-left (`in_op`=2) with offset k keeps the memory bytes above byte k. It fills bytes 0..k with register bytes 3-k..3, meaning the register is shifted right by 8*(3-k) bits. At offset 3 the result is the whole register.
- R6: Store-right (`in_op`=3) with offset k keeps memory bytes below byte k. It fills bytes k..3 with register bytes 0..3-k, meaning the register is shifted left by 8*k bits.
- R7: For a store, bit j of `out_be` (byte j = bits 8j+7..8j) is 1 exactly for the bytes taken from the register: bits 0..k for store-left, bits k..3 for store-right. Bytes with a 0 enable equal the old memory word. For a load, `out_be` is 0000.
- R8: Load-left at offset (a+3) mod 4 on the aligned word W1 holding address A+3, followed by load-right at offset a on the aligned word W0 holding A (with the first result as register input), yields bits 31..0 of {W1,W0} shifted right by 8*a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 load-left, 1 load-right, 2 store-left, 3 store-right |
| in_ofs | input | 2 | Byte offset, address bits [1:0] |
| in_mem | input | 32 | Aligned memory word |
| in_reg | input | 32 | Current register value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 32 | Merged register value (loads) or merged memory word (stores) |
| out_be | output | 4 | Byte enables of changed bytes for stores, zero for loads |

## Verification
Every result is due one rising edge after its request. The merged word, the byte enables and the valid strobe all arrive in that same cycle, because a single output register sits behind the combinational merge. The driver changes inputs on the falling edge and pushes the expected word and enables into a queue. The monitor samples on the following falling edge, after the capturing rising edge, and pops one entry each time `out_valid` is high. A request therefore meets its expectation exactly one cycle later, and any early, late, missing or extra result shows up as a mismatch or a leftover entry. The hold behaviour and the left/right pair are checked at the same half-cycle sampling point, and the pair feeds the first result back as the register input of the second request.

// File: rtl/pwm_pkg.sv
// Shared types for the partial-word merger.
// Assumes the operation code is two bits; bit 1 separates stores from loads.
package pwm_pkg;

    typedef enum logic [1:0] {
        OP_LOAD_LEFT   = 2'd0,
        OP_LOAD_RIGHT  = 2'd1,
        OP_STORE_LEFT  = 2'd2,
        OP_STORE_RIGHT = 2'd3
    } merge_op_e;

endpackage

// File: rtl/pwm_lane_ctrl.sv
// Decodes operation and byte offset into a per-lane keep mask, a byte shift
// amount and a shift direction. Purely combinational.
// Assumes NB is a power of two so that the offset spans all lanes.
module pwm_lane_ctrl #(
    parameter  int NB = 4,
    localparam int OW = $clog2(NB)
) (
    input  logic [1:0]    op,
    input  logic [OW-1:0] ofs,
    output logic [NB-1:0] keep,
    output logic [OW-1:0] shamt,
    output logic          shl,
    output logic          is_store
);
    import pwm_pkg::*;

    localparam logic [OW-1:0] TOP_LANE = OW'(NB - 1);

    merge_op_e op_e;
    int        ofs_i;

    assign op_e  = merge_op_e'(op);
    assign ofs_i = int'(ofs);

    // Choose shift amount and direction for the moving word.
    always_comb begin
        shamt    = ofs;
        shl      = 1'b1;
        is_store = 1'b0;
        case (op_e)
            OP_LOAD_LEFT:   begin shamt = TOP_LANE - ofs; shl = 1'b1; end
            OP_LOAD_RIGHT:  begin shamt = ofs;            shl = 1'b0; end
            OP_STORE_LEFT:  begin shamt = TOP_LANE - ofs; shl = 1'b0; is_store = 1'b1; end
            OP_STORE_RIGHT: begin shamt = ofs;            shl = 1'b1; is_store = 1'b1; end
            default:        begin shamt = ofs;            shl = 1'b1; end
        endcase
    end

    // One keep decision per byte lane.
    for (genvar j = 0; j < NB; j++) begin : g_lane
        assign keep[j] = (op_e == OP_LOAD_LEFT)  ? ((j + ofs_i) < (NB - 1)) :
                         (op_e == OP_LOAD_RIGHT) ? ((j + ofs_i) >= NB)      :
                         (op_e == OP_STORE_LEFT) ? (j > ofs_i)              :
                                                   (j < ofs_i);
    end

endmodule

// File: rtl/pwm_byte_shift.sv
// Shifts a word by a whole number of bytes, left or right, zero filling.
// Assumes the amount never exceeds NB-1 lanes.
module pwm_byte_shift #(
    parameter  int NB = 4,
    localparam int OW = $clog2(NB),
    localparam int W  = 8 * NB
) (
    input  logic [W-1:0]  din,
    input  logic [OW-1:0] amt,
    input  logic          shl,
    output logic [W-1:0]  dout
);
    logic [OW+2:0] bit_amt;

    assign bit_amt = {amt, 3'b000};

    // Byte-granular barrel shift in the requested direction.
    always_comb begin
        if (shl) dout = din << bit_amt;
        else     dout = din >> bit_amt;
    end

endmodule

// File: rtl/pwm_byte_merge.sv
// Per-lane select between the kept base word and the shifted word.
// Assumes shifted bytes in kept lanes are don't-care (they are zero anyway).
module pwm_byte_merge #(
    parameter  int NB = 4,
    localparam int W  = 8 * NB
) (
    input  logic [W-1:0]  base,
    input  logic [W-1:0]  moved,
    input  logic [NB-1:0] keep,
    output logic [W-1:0]  merged
);
    // Each lane picks its byte from the base or from the moved word.
    for (genvar j = 0; j < NB; j++) begin : g_lane
        assign merged[8*j +: 8] = keep[j] ? base[8*j +: 8] : moved[8*j +: 8];
    end

endmodule

// File: rtl/partial_word_merge.sv
// Merger for the left/right partial-word loads and stores of a little-endian
// core. Combinational decode, shift and merge, then one output register.
// Assumes the caller has already fetched the aligned word; the offset only
// steers the merge, so no alignment fault exists here.
module partial_word_merge #(
    parameter  int NB = 4,
    localparam int OW = $clog2(NB),
    localparam int W  = 8 * NB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    in_op,
    input  logic [OW-1:0] in_ofs,
    input  logic [W-1:0]  in_mem,
    input  logic [W-1:0]  in_reg,
    output logic          out_valid,
    output logic [W-1:0]  out_word,
    output logic [NB-1:0] out_be
);
    logic [NB-1:0] keep;
    logic [OW-1:0] shamt;
    logic          shl;
    logic          is_store;
    logic [W-1:0]  base_w;
    logic [W-1:0]  src_w;
    logic [W-1:0]  moved_w;
    logic [W-1:0]  merged_w;
    logic [NB-1:0] be_w;

    pwm_lane_ctrl #(.NB(NB)) ctrl_i (
        .op       (in_op),
        .ofs      (in_ofs),
        .keep     (keep),
        .shamt    (shamt),
        .shl      (shl),
        .is_store (is_store)
    );

    // Loads keep register bytes and move memory; stores do the reverse.
    always_comb begin
        base_w = is_store ? in_mem : in_reg;
        src_w  = is_store ? in_reg : in_mem;
        be_w   = is_store ? ~keep  : '0;
    end

    pwm_byte_shift #(.NB(NB)) shift_i (
        .din  (src_w),
        .amt  (shamt),
        .shl  (shl),
        .dout (moved_w)
    );

    pwm_byte_merge #(.NB(NB)) merge_i (
        .base   (base_w),
        .moved  (moved_w),
        .keep   (keep),
        .merged (merged_w)
    );

    // Output register: capture on a valid request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_be    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= merged_w;
                out_be   <= be_w;
            end
        end
    end

endmodule

// File: rtl/pwm_checker.sv
// Protocol and merge properties for partial_word_merge, bound to the top.
// Assumes the operation encoding of the brief (bit 1 set means store).
module pwm_checker #(
    parameter  int NB = 4,
    localparam int OW = $clog2(NB),
    localparam int W  = 8 * NB
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic [OW-1:0] in_ofs,
    input logic [W-1:0]  in_mem,
    input logic [W-1:0]  in_reg,
    input logic          out_valid,
    input logic [W-1:0]  out_word,
    input logic [NB-1:0] out_be
);
    logic [W-1:0] be_bits;

    // Widen each enable to a byte-wide mask.
    for (genvar j = 0; j < NB; j++) begin : g_be
        assign be_bits[8*j +: 8] = {8{out_be[j]}};
    end

    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));

    // R4
    right_load_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd1 && in_ofs == '0) |=> out_word == $past(in_mem));

    // R5
    left_store_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd2 && in_ofs == OW'(NB - 1)) |=> out_word == $past(in_reg));

    // R7
    store_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1]) |=> ((out_word ^ $past(in_mem)) & ~be_bits) == '0);

    // R7
    load_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[1]) |=> out_be == '0);

    // R7
    store_left_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd2) |=> out_be[0]);

    // R7
    store_right_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd3) |=> out_be[NB-1]);

endmodule

bind partial_word_merge pwm_checker #(.NB(NB)) chk_i (.*);

// File: tb/partial_word_merge_tb.sv
// Scoreboard bench for partial_word_merge: the driver queues expectations,
// the monitor pops and compares each result one cycle after its request.
module partial_word_merge_tb_top;

    typedef struct {
        logic [31:0] word;
        logic [3:0]  be;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic [1:0]  in_ofs = '0;
    logic [31:0] in_mem = '0;
    logic [31:0] in_reg = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [3:0]  out_be;

    int   total = 0;
    int   bad = 0;
    exp_t sb_q[$];

    partial_word_merge dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_ofs    (in_ofs),
        .in_mem    (in_mem),
        .in_reg    (in_reg),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_be    (out_be)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Byte-by-byte reference built from the requirement text.
    function automatic logic [35:0] model(input logic [1:0] op, input int k,
                                          input logic [31:0] m, input logic [31:0] r);
        logic [31:0] w;
        logic [3:0]  be;
        w  = '0;
        be = '0;
        for (int j = 0; j < 4; j++) begin
            case (op)
                2'd0: if (j < 3 - k) w[8*j +: 8] = r[8*j +: 8];
                      else           w[8*j +: 8] = m[8*(j - (3 - k)) +: 8];
                2'd1: if (j >= 4 - k) w[8*j +: 8] = r[8*j +: 8];
                      else            w[8*j +: 8] = m[8*(j + k) +: 8];
                2'd2: if (j > k) w[8*j +: 8] = m[8*j +: 8];
                      else begin w[8*j +: 8] = r[8*(j + 3 - k) +: 8]; be[j] = 1'b1; end
                default: if (j < k) w[8*j +: 8] = m[8*j +: 8];
                         else begin w[8*j +: 8] = r[8*(j - k) +: 8]; be[j] = 1'b1; end
            endcase
        end
        return {be, w};
    endfunction

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5/R7";
            default: return "R6/R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_op(input logic [1:0] op, input logic [1:0] k, input logic [31:0] m,
                           input logic [31:0] r, input logic [31:0] w, input logic [3:0] be,
                           input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_ofs   = k;
        in_mem   = m;
        in_reg   = r;
        e.word = w;
        e.be   = be;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    task automatic do_op(input logic [1:0] op, input logic [1:0] k,
                         input logic [31:0] m, input logic [31:0] r);
        logic [35:0] x;
        x = model(op, int'(k), m, r);
        push_op(op, k, m, r, x[31:0], x[35:32], op_req(op));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_mem   = $urandom;
        in_reg   = $urandom;
    endtask

    // Monitor: one result per cycle after a valid request.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R2: unexpected result actual=%h expected=none", out_word);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, {out_be, out_word}, {e.be, e.word});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] first;
        logic [63:0] pairw;
        in_valid = 1'b1;
        in_mem   = 32'hDEAD_BEEF;
        in_reg   = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears the outputs even with a request present
        check("R1", {out_valid, out_be, out_word}, 37'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;

        // R3 R4 R5 R6 R7: every operation at every offset, two patterns
        for (int op = 0; op < 4; op++)
            for (int k = 0; k < 4; k++) begin
                do_op(op[1:0], k[1:0], 32'hA1B2_C3D4, 32'h5566_7788);
                do_op(op[1:0], k[1:0], 32'hFFFF_FFFF, 32'h0000_0000);
            end
        // R3 R4 R5 R6 R7: back-to-back random requests
        for (int i = 0; i < 200; i++)
            do_op(2'($urandom), 2'($urandom), $urandom, $urandom);
        idle();

        // R2: output holds over idle cycles
        do_op(2'd3, 2'd2, 32'h0102_0304, 32'hCAFE_F00D);
        idle();
        held = out_word;
        idle();
        idle();
        check("R2", {3'b0, out_valid, out_word}, {4'b0, held});

        // R8: left/right load pair assembles the misaligned word
        for (int a = 0; a < 4; a++) begin
            w0 = $urandom;
            w1 = (a == 0) ? w0 : $urandom;
            do_op(2'd0, 2'(a + 3), w1, 32'h9999_9999);
            idle();
            first = out_word;
            pairw = {w1, w0} >> (8 * a);
            push_op(2'd1, 2'(a), w0, first, pairw[31:0], 4'b0000, "R8");
            idle();
        end

        repeat (3) idle();
        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2: missing results actual=%0d expected=0", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule